// File: doc/BRIEF.md
# Buffered Command/Response Register Bank

This block is the byte-wide register file that sits behind a host SPI port and in front of a set of serial sensor buses. Each bus owns several buffer slots. Each slot keeps an outbound command word that the host writes one byte at a time. It also keeps a readback copy that the bus side overwrites whenever it stores a received word. A read-only status byte per slot shows whether the last received word had a bad CRC and whether the outbound word is still waiting to be taken by the bus side.

The host side arrives already deserialised. A byte write is a single-cycle `host_wr_valid` beat carrying an address, the data, a first-byte-of-burst marker and a framing-error flag. Chip select `cs_n` frames a burst. The block never exerts back-pressure: every valid beat is taken in the cycle it is presented, and the block decides from the rules below whether the beat has any effect. Reads are a plain combinational lookup of `host_rd_addr`. The status bytes the host sees are frozen for the whole time chip select is low, so one burst never reads a half-updated picture. A completed high-then-low pair raises `sched_valid` for one clock, together with the slot index, to ask the bus engine to start a transaction.

The bus side stores received words through `rx_valid`. It reports that it has consumed the outbound word of a slot through `tx_take`, and it reads that word on `tx_word`. A per-bus `chan_off` level returns every slot of that bus to its reset state.

Top module: `cmd_resp_bank`

## Requirements
- R1: After reset every data byte reads 0x00, every status byte reads 0x41, and `sched_valid` is low.
- R2: In one chip-select-low burst, an accepted high-byte write to a slot followed later by an accepted low-byte write to the same slot raises `sched_valid` in the clock after the low byte, for exactly one clock, with `sched_slot` equal to that slot. `tx_word` for the slot is then {high, low}.
- R3: A byte written with `host_wr_ferr` high is discarded and cancels any pending high byte of that slot. A low byte with no pending high byte in the same burst schedules nothing. Raising `cs_n` cancels all pending high bytes.
- R4: If the beat marked `host_wr_first` addresses a low byte (addr[5:4]=1) or a status byte (addr[5:4]=2), that beat and every later beat until `cs_n` rises have no effect. Only a high-byte address (addr[5:4]=0) on the first beat opens a burst.
- R5: Address fields: addr[5:4] selects high (0), low (1) or status (2); 3 reads 0x00. addr[3:0] is the slot, and slot = bus*4 + buffer. A stored received word puts bits 15:8 in the high byte and bits 7:0 in the low byte. When a received word and a host write reach the same slot in the same clock, the readback takes the received word and `tx_word` takes the host byte.
- R6: Status bit 7 equals `rx_crc_bad` of the most recent word stored into that slot.
- R7: Status bit 6 is cleared by an accepted host write to either data byte of the slot. It is set by `tx_take` for that slot. A write and a take in the same clock leave it cleared. Bits 5..1 read 0 and bit 0 reads 1.
- R8: While `cs_n` is low the status bytes hold the value they had when it fell. Changes made meanwhile become visible one clock after `cs_n` is sampled high.
- R9: While `chan_off[b]` is high, slots 4b..4b+3 return to the R1 values, lose any pending high byte and cannot schedule. Other buses are untouched.
- R10: Writes to status addresses, and any write while `cs_n` is high, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, low frames a burst |
| host_wr_valid | input | 1 | Host byte write beat, always accepted |
| host_wr_first | input | 1 | Beat is the first of its burst |
| host_wr_ferr | input | 1 | Beat carried a framing error |
| host_wr_addr | input | 6 | Write address {kind[1:0], slot[3:0]} |
| host_wr_data | input | 8 | Write data byte |
| host_rd_addr | input | 6 | Read address {kind[1:0], slot[3:0]} |
| host_rd_data | output | 8 | Read data for host_rd_addr |
| rx_valid | input | 1 | Store a received word this clock |
| rx_slot | input | 4 | Slot receiving the word |
| rx_word | input | 16 | Received word |
| rx_crc_bad | input | 1 | Received word failed its CRC |
| tx_slot | input | 4 | Slot whose outbound word is shown and taken |
| tx_take | input | 1 | Bus side consumed the outbound word of tx_slot |
| tx_word | output | 16 | Outbound word {high, low} of tx_slot |
| chan_off | input | 4 | Per-bus shutdown/disable, level |
| sched_valid | output | 1 | One-clock transaction request |
| sched_slot | output | 4 | Slot of the requested transaction |

## Verification
The assertions check on every cycle the conditions around a schedule pulse: that it follows a clean low-byte beat taken inside chip select, that its slot index matches that beat, and that it never follows a clock in which its bus was shut down. They also check that the whole status image stays still while chip select stays low. The ordering rules need the bench's scenarios: the pairing of high before low within one burst, abort on a wrong first address, received-word priority over a host write, write-over-take on the empty flag, and the one-clock delay before deferred status appears. A behavioural model compared on every clock also covers long random traffic with chip-select toggling and channel shutdowns.

// File: rtl/cmd_resp_pkg.sv
package cmd_resp_pkg;

  typedef enum logic [1:0] {
    RK_HI   = 2'd0,
    RK_LO   = 2'd1,
    RK_STAT = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;

  localparam logic [7:0] STAT_RESET = 8'h41;

  // status byte: [7] crc bad, [6] tx empty, [5:1] zero, [0] one
  function automatic logic [7:0] stat_byte(input logic er, input logic te);
    return {er, te, 5'b00000, 1'b1};
  endfunction

endpackage

// File: rtl/cmd_resp_slot.sv
module cmd_resp_slot
  import cmd_resp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cs_n,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [7:0]  wr_data,
  input  logic        rx_store,
  input  logic [15:0] rx_word,
  input  logic        rx_bad,
  input  logic        take,
  output logic [15:0] tx_word,
  output logic [7:0]  rd_hi,
  output logic [7:0]  rd_lo,
  output logic [7:0]  stat_snap
);

  logic [7:0] tx_hi_q, tx_lo_q, rd_hi_q, rd_lo_q, snap_q;
  logic       er_q, te_q;

  // outbound buffer: only host writes touch it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hi_q <= '0;
      tx_lo_q <= '0;
    end else if (clr) begin
      tx_hi_q <= '0;
      tx_lo_q <= '0;
    end else begin
      if (wr_hi) tx_hi_q <= wr_data;
      if (wr_lo) tx_lo_q <= wr_data;
    end
  end

  // readback copy: received word wins over host byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi_q <= '0;
      rd_lo_q <= '0;
    end else if (clr) begin
      rd_hi_q <= '0;
      rd_lo_q <= '0;
    end else if (rx_store) begin
      rd_hi_q <= rx_word[15:8];
      rd_lo_q <= rx_word[7:0];
    end else begin
      if (wr_hi) rd_hi_q <= wr_data;
      if (wr_lo) rd_lo_q <= wr_data;
    end
  end

  // live flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      er_q <= 1'b0;
      te_q <= 1'b1;
    end else if (clr) begin
      er_q <= 1'b0;
      te_q <= 1'b1;
    end else begin
      if (rx_store) er_q <= rx_bad;
      if (wr_hi || wr_lo) te_q <= 1'b0;
      else if (take)      te_q <= 1'b1;
    end
  end

  // host-visible copy follows live flags only while select is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= STAT_RESET;
    else if (clr)   snap_q <= STAT_RESET;
    else if (cs_n)  snap_q <= stat_byte(er_q, te_q);
  end

  assign tx_word   = {tx_hi_q, tx_lo_q};
  assign rd_hi     = rd_hi_q;
  assign rd_lo     = rd_lo_q;
  assign stat_snap = snap_q;

endmodule

// File: rtl/cmd_resp_burst.sv
module cmd_resp_burst
  import cmd_resp_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SW        = 4,
  parameter int AW        = SW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 wr_valid,
  input  logic                 wr_first,
  input  logic                 wr_ferr,
  input  logic [AW-1:0]        wr_addr,
  input  logic [NUM_SLOTS-1:0] slot_clr,
  output logic [NUM_SLOTS-1:0] wr_hi_oh,
  output logic [NUM_SLOTS-1:0] wr_lo_oh,
  output logic                 sched_valid,
  output logic [SW-1:0]        sched_slot
);

  reg_kind_e      kind;
  logic [SW-1:0]  slot;
  logic           ign_q, ign_now, in_burst, data_beat, accept, fire;
  logic [NUM_SLOTS-1:0] pend_q;

  assign kind      = reg_kind_e'(wr_addr[AW-1:AW-2]);
  assign slot      = wr_addr[SW-1:0];
  assign in_burst  = wr_valid && !cs_n;
  assign ign_now   = wr_first ? (kind != RK_HI) : ign_q;
  assign data_beat = in_burst && !ign_now && (kind == RK_HI || kind == RK_LO);
  assign accept    = data_beat && !wr_ferr;
  assign fire      = accept && (kind == RK_LO) && pend_q[slot] && !slot_clr[slot];

  // burst abort decision, made on the first beat and held to select release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ign_q <= 1'b0;
    else if (cs_n)               ign_q <= 1'b0;
    else if (wr_valid && wr_first) ign_q <= (kind != RK_HI);
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic hit;
    assign hit         = (slot == SW'(i));
    assign wr_hi_oh[i] = accept && hit && (kind == RK_HI);
    assign wr_lo_oh[i] = accept && hit && (kind == RK_LO);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pend_q[i] <= 1'b0;
      else if (cs_n || slot_clr[i]) pend_q[i] <= 1'b0;
      else if (data_beat && hit) pend_q[i] <= (kind == RK_HI) && !wr_ferr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sched_valid <= 1'b0;
      sched_slot  <= '0;
    end else begin
      sched_valid <= fire;
      if (fire) sched_slot <= slot;
    end
  end

endmodule

// File: rtl/cmd_resp_mux.sv
module cmd_resp_mux
  import cmd_resp_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SW        = 4,
  parameter int AW        = SW + 2
) (
  input  logic [AW-1:0]                 rd_addr,
  input  logic [NUM_SLOTS-1:0][7:0]     hi_all,
  input  logic [NUM_SLOTS-1:0][7:0]     lo_all,
  input  logic [NUM_SLOTS-1:0][7:0]     stat_all,
  input  logic [NUM_SLOTS-1:0][15:0]    tx_all,
  input  logic [SW-1:0]                 tx_sel,
  output logic [7:0]                    rd_data,
  output logic [15:0]                   tx_word
);

  reg_kind_e     kind;
  logic [SW-1:0] slot;

  assign kind = reg_kind_e'(rd_addr[AW-1:AW-2]);
  assign slot = rd_addr[SW-1:0];

  always_comb begin
    unique case (kind)
      RK_HI:   rd_data = hi_all[slot];
      RK_LO:   rd_data = lo_all[slot];
      RK_STAT: rd_data = stat_all[slot];
      default: rd_data = 8'h00;
    endcase
  end

  assign tx_word = tx_all[tx_sel];

endmodule

// File: rtl/cmd_resp_bank.sv
module cmd_resp_bank
  import cmd_resp_pkg::*;
#(
  parameter  int NUM_BUS       = 4,
  parameter  int SLOTS_PER_BUS = 4,
  localparam int NUM_SLOTS     = NUM_BUS * SLOTS_PER_BUS,
  localparam int SW            = $clog2(NUM_SLOTS),
  localparam int AW            = SW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               host_wr_valid,
  input  logic               host_wr_first,
  input  logic               host_wr_ferr,
  input  logic [AW-1:0]      host_wr_addr,
  input  logic [7:0]         host_wr_data,
  input  logic [AW-1:0]      host_rd_addr,
  output logic [7:0]         host_rd_data,
  input  logic               rx_valid,
  input  logic [SW-1:0]      rx_slot,
  input  logic [15:0]        rx_word,
  input  logic               rx_crc_bad,
  input  logic [SW-1:0]      tx_slot,
  input  logic               tx_take,
  output logic [15:0]        tx_word,
  input  logic [NUM_BUS-1:0] chan_off,
  output logic               sched_valid,
  output logic [SW-1:0]      sched_slot
);

  localparam int BUF_W = $clog2(SLOTS_PER_BUS);

  logic [NUM_SLOTS-1:0]        slot_clr, wr_hi_oh, wr_lo_oh;
  logic [NUM_SLOTS-1:0][7:0]   hi_all, lo_all, status_snap_all;
  logic [NUM_SLOTS-1:0][15:0]  tx_all;

  cmd_resp_burst #(.NUM_SLOTS(NUM_SLOTS), .SW(SW), .AW(AW)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .wr_valid   (host_wr_valid),
    .wr_first   (host_wr_first),
    .wr_ferr    (host_wr_ferr),
    .wr_addr    (host_wr_addr),
    .slot_clr   (slot_clr),
    .wr_hi_oh   (wr_hi_oh),
    .wr_lo_oh   (wr_lo_oh),
    .sched_valid(sched_valid),
    .sched_slot (sched_slot)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_clr[i] = chan_off[i >> BUF_W];

    cmd_resp_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (slot_clr[i]),
      .cs_n     (cs_n),
      .wr_hi    (wr_hi_oh[i]),
      .wr_lo    (wr_lo_oh[i]),
      .wr_data  (host_wr_data),
      .rx_store (rx_valid && (rx_slot == SW'(i))),
      .rx_word  (rx_word),
      .rx_bad   (rx_crc_bad),
      .take     (tx_take && (tx_slot == SW'(i))),
      .tx_word  (tx_all[i]),
      .rd_hi    (hi_all[i]),
      .rd_lo    (lo_all[i]),
      .stat_snap(status_snap_all[i])
    );
  end

  cmd_resp_mux #(.NUM_SLOTS(NUM_SLOTS), .SW(SW), .AW(AW)) u_mux (
    .rd_addr (host_rd_addr),
    .hi_all  (hi_all),
    .lo_all  (lo_all),
    .stat_all(status_snap_all),
    .tx_all  (tx_all),
    .tx_sel  (tx_slot),
    .rd_data (host_rd_data),
    .tx_word (tx_word)
  );

endmodule

// File: rtl/cmd_resp_bank_chk.sv
module cmd_resp_bank_chk
  import cmd_resp_pkg::*;
#(
  parameter int NUM_BUS       = 4,
  parameter int SLOTS_PER_BUS = 4,
  parameter int NUM_SLOTS     = 16,
  parameter int SW            = 4,
  parameter int AW            = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       host_wr_valid,
  input logic                       host_wr_ferr,
  input logic [AW-1:0]              host_wr_addr,
  input logic [NUM_BUS-1:0]         chan_off,
  input logic                       sched_valid,
  input logic [SW-1:0]              sched_slot,
  input logic [NUM_SLOTS-1:0][7:0]  status_all
);

  localparam int BUF_W = $clog2(SLOTS_PER_BUS);

  logic [NUM_BUS-1:0] off_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= chan_off;
  end

  // R2: a request follows a low-byte beat taken inside chip select
  a_r2_after_low_beat: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |-> $past(host_wr_valid && !cs_n &&
                          host_wr_addr[AW-1:AW-2] == 2'(RK_LO)));

  // R2: request carries the slot of that beat
  a_r2_slot_matches: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |-> sched_slot == $past(host_wr_addr[SW-1:0]));

  // R3: a framing-error beat never triggers a request
  a_r3_no_sched_on_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |-> !$past(host_wr_ferr));

  // R9: a shut-down bus never requests
  a_r9_off_blocks_sched: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |-> !off_q[sched_slot[SW-1:BUF_W]]);

  // R8: status image frozen while select stays low
  a_r8_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cs_n) && $past(chan_off) == '0) |-> $stable(status_all));

endmodule

bind cmd_resp_bank cmd_resp_bank_chk #(
  .NUM_BUS      (NUM_BUS),
  .SLOTS_PER_BUS(SLOTS_PER_BUS),
  .NUM_SLOTS    (NUM_SLOTS),
  .SW           (SW),
  .AW           (AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .host_wr_valid(host_wr_valid),
  .host_wr_ferr (host_wr_ferr),
  .host_wr_addr (host_wr_addr),
  .chan_off     (chan_off),
  .sched_valid  (sched_valid),
  .sched_slot   (sched_slot),
  .status_all   (status_snap_all)
);

// File: tb/tb_cmd_resp_bank.sv
`timescale 1ns/1ps
module tb_cmd_resp_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        host_wr_valid = 1'b0, host_wr_first = 1'b0, host_wr_ferr = 1'b0;
  logic [5:0]  host_wr_addr = '0;
  logic [7:0]  host_wr_data = '0;
  logic [5:0]  host_rd_addr;
  logic [7:0]  host_rd_data;
  logic        rx_valid = 1'b0, rx_crc_bad = 1'b0;
  logic [3:0]  rx_slot = '0;
  logic [15:0] rx_word = '0;
  logic [3:0]  tx_slot = '0;
  logic        tx_take = 1'b0;
  logic [15:0] tx_word;
  logic [3:0]  chan_off = '0;
  logic        sched_valid;
  logic [3:0]  sched_slot;

  cmd_resp_bank dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .host_wr_valid(host_wr_valid), .host_wr_first(host_wr_first),
    .host_wr_ferr(host_wr_ferr), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr),
    .host_rd_data(host_rd_data), .rx_valid(rx_valid), .rx_slot(rx_slot),
    .rx_word(rx_word), .rx_crc_bad(rx_crc_bad), .tx_slot(tx_slot),
    .tx_take(tx_take), .tx_word(tx_word), .chan_off(chan_off),
    .sched_valid(sched_valid), .sched_slot(sched_slot)
  );

  always #10 clk = ~clk;

  localparam logic [1:0] HI = 2'd0, LO = 2'd1, ST = 2'd2;

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] mtxh [16], mtxl [16], mrdh [16], mrdl [16], msnap [16];
  bit         mer [16], mte [16], mpend [16];
  bit         mign, msv;
  logic [3:0] mss;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 16; s++) begin
        mtxh[s] = 0; mtxl[s] = 0; mrdh[s] = 0; mrdl[s] = 0;
        msnap[s] = 8'h41; mer[s] = 0; mte[s] = 1; mpend[s] = 0;
      end
      mign = 0; msv = 0; mss = 0;
    end else begin
      bit ign, inb, beat, acc, fire;
      int kd, sl;
      kd = host_wr_addr[5:4];
      sl = host_wr_addr[3:0];
      for (int s = 0; s < 16; s++)
        if (cs_n) msnap[s] = {mer[s], mte[s], 6'b000001};
      ign  = host_wr_first ? (kd != 0) : mign;
      inb  = host_wr_valid && !cs_n;
      beat = inb && !ign && (kd <= 1);
      acc  = beat && !host_wr_ferr;
      fire = acc && kd == 1 && mpend[sl] && !chan_off[sl/4];
      if (cs_n) mign = 0;
      else if (host_wr_valid && host_wr_first) mign = (kd != 0);
      if (beat) mpend[sl] = (kd == 0) && !host_wr_ferr;
      if (cs_n) for (int s = 0; s < 16; s++) mpend[s] = 0;
      if (tx_take) mte[tx_slot] = 1;
      if (acc) begin
        if (kd == 0) begin mtxh[sl] = host_wr_data; mrdh[sl] = host_wr_data; end
        else         begin mtxl[sl] = host_wr_data; mrdl[sl] = host_wr_data; end
        mte[sl] = 0;
      end
      if (rx_valid) begin
        mrdh[rx_slot] = rx_word[15:8]; mrdl[rx_slot] = rx_word[7:0];
        mer[rx_slot] = rx_crc_bad;
      end
      for (int s = 0; s < 16; s++)
        if (chan_off[s/4]) begin
          mtxh[s] = 0; mtxl[s] = 0; mrdh[s] = 0; mrdl[s] = 0;
          msnap[s] = 8'h41; mer[s] = 0; mte[s] = 1; mpend[s] = 0;
        end
      msv = fire;
      if (fire) mss = 4'(sl);
    end
  end

  // ---------------- per-clock comparison ----------------
  bit         hold = 1'b1;
  logic [5:0] fix_addr = '0;
  int         sweep = 0;

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    host_rd_addr = hold ? fix_addr : {2'((sweep / 16) % 3), 4'(sweep % 16)};
    sweep++;
    #5;
    if (rst_n) begin
      case (host_rd_addr[5:4])
        2'd0: exp_rd = mrdh[host_rd_addr[3:0]];
        2'd1: exp_rd = mrdl[host_rd_addr[3:0]];
        2'd2: exp_rd = msnap[host_rd_addr[3:0]];
        default: exp_rd = 8'h00;
      endcase
      chk(host_rd_addr[5:4] == 2'd2 ? "R8 model status" : "R5 model readback",
          32'(host_rd_data), 32'(exp_rd));
      chk("R5 model tx_word", 32'(tx_word), {16'h0, mtxh[tx_slot], mtxl[tx_slot]});
      chk("R2 model sched_valid", 32'(sched_valid), 32'(msv));
      if (msv) chk("R2 model sched_slot", 32'(sched_slot), 32'(mss));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input bit wv, input bit first, input logic [5:0] a,
                       input logic [7:0] d, input bit fe,
                       input bit rv, input logic [3:0] rs, input logic [15:0] rw,
                       input bit rb, input bit tk);
    @(negedge clk);
    host_wr_valid = wv; host_wr_first = first; host_wr_addr = a;
    host_wr_data = d; host_wr_ferr = fe;
    rx_valid = rv; rx_slot = rs; rx_word = rw; rx_crc_bad = rb; tx_take = tk;
    @(negedge clk);
    host_wr_valid = 0; host_wr_first = 0; host_wr_ferr = 0;
    rx_valid = 0; rx_crc_bad = 0; tx_take = 0;
  endtask

  task automatic wr(input bit first, input logic [1:0] k, input int s,
                    input logic [7:0] d, input bit fe = 0);
    drive(1, first, {k, 4'(s)}, d, fe, 0, 0, 0, 0, 0);
  endtask

  task automatic rx(input int s, input logic [15:0] w, input bit bad);
    drive(0, 0, 0, 0, 0, 1, 4'(s), w, bad, 0);
  endtask

  task automatic sel(input bit v);
    @(negedge clk); cs_n = v;
  endtask

  task automatic rd(input string tag, input logic [1:0] k, input int s,
                    input logic [7:0] exp);
    @(negedge clk); hold = 1; fix_addr = {k, 4'(s)};
    @(negedge clk); #5;
    chk(tag, 32'(host_rd_data), 32'(exp));
  endtask

  task automatic peek(input string tag, input logic [31:0] act, input logic [31:0] exp);
    #5; chk(tag, act, exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1 reset status", ST, 3, 8'h41);
    rd("R1 reset high byte", HI, 5, 8'h00);
    chk("R1 reset sched_valid", 32'(sched_valid), 0);

    // R2 complete pair
    tx_slot = 3;
    sel(0);
    wr(1, HI, 3, 8'hA5);
    wr(0, LO, 3, 8'h5A);
    peek("R2 pulse high", 32'(sched_valid), 1);
    chk("R2 pulse slot", 32'(sched_slot), 3);
    chk("R2 tx_word", 32'(tx_word), 32'hA55A);
    @(negedge clk); peek("R2 pulse one clock", 32'(sched_valid), 0);
    rd("R8 status frozen during select", ST, 3, 8'h41);
    sel(1);
    rd("R7 tx not empty after write", ST, 3, 8'h01);
    rd("R5 high readback", HI, 3, 8'hA5);

    // R3 framing error and orphan low byte
    sel(0);
    wr(1, HI, 4, 8'hC3);
    wr(0, LO, 4, 8'h3C, 1);
    peek("R3 no pulse on ferr", 32'(sched_valid), 0);
    rd("R3 ferr byte discarded", LO, 4, 8'h00);
    wr(0, LO, 4, 8'h99);
    peek("R3 ferr cancelled pending", 32'(sched_valid), 0);
    sel(1);
    sel(0);
    wr(1, HI, 9, 8'h11);
    wr(0, LO, 8, 8'h22);
    peek("R3 low without high", 32'(sched_valid), 0);
    sel(1);

    // R4 burst opened on a low or status address
    sel(0);
    wr(1, LO, 6, 8'h11);
    wr(0, HI, 6, 8'h22);
    wr(0, LO, 6, 8'h33);
    peek("R4 no pulse in aborted burst", 32'(sched_valid), 0);
    sel(1);
    rd("R4 high untouched", HI, 6, 8'h00);
    rd("R4 low untouched", LO, 6, 8'h00);
    rd("R4 status untouched", ST, 6, 8'h41);
    sel(0);
    wr(1, ST, 6, 8'h44);
    wr(0, HI, 6, 8'h55);
    wr(0, LO, 6, 8'h66);
    peek("R4 no pulse after status start", 32'(sched_valid), 0);
    sel(1);
    rd("R4 high untouched after status start", HI, 6, 8'h00);

    // R5 / R6 received words
    rx(10, 16'h1234, 1);
    rd("R5 rx high byte", HI, 10, 8'h12);
    rd("R5 rx low byte", LO, 10, 8'h34);
    rd("R6 crc bad flag", ST, 10, 8'hC1);
    rx(10, 16'hFFFF, 0);
    rd("R6 crc flag cleared", ST, 10, 8'h41);

    // R5 priority of received word over host byte
    sel(0);
    drive(1, 1, {HI, 4'd11}, 8'h77, 0, 1, 4'd11, 16'hBEEF, 0, 0);
    sel(1);
    rd("R5 rx wins readback", HI, 11, 8'hBE);
    tx_slot = 11;
    @(negedge clk); peek("R5 host byte kept in tx", 32'(tx_word), 32'h7700);
    rd("R7 host write cleared empty", ST, 11, 8'h01);

    // R7 take, and write-over-take
    @(negedge clk); tx_slot = 3;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    rd("R7 take sets empty", ST, 3, 8'h41);
    @(negedge clk); tx_slot = 2;
    sel(0);
    drive(1, 1, {HI, 4'd2}, 8'h10, 0, 0, 0, 0, 0, 1);
    sel(1);
    rd("R7 write beats take", ST, 2, 8'h01);

    // R9 channel shutdown
    @(negedge clk); chan_off = 4'b0001;
    @(negedge clk); chan_off = 4'b0000;
    rd("R9 status reset", ST, 2, 8'h41);
    rd("R9 high reset", HI, 3, 8'h00);
    @(negedge clk); tx_slot = 3;
    @(negedge clk); peek("R9 tx cleared", 32'(tx_word), 0);
    rd("R9 other bus kept", HI, 4, 8'hC3);
    sel(0);
    wr(1, HI, 1, 8'h05);
    @(negedge clk); chan_off = 4'b0001;
    @(negedge clk); chan_off = 4'b0000;
    wr(0, LO, 1, 8'h06);
    peek("R9 pending dropped", 32'(sched_valid), 0);
    sel(1);

    // R10 ignored writes
    sel(0);
    wr(1, HI, 12, 8'hAB);
    wr(0, ST, 12, 8'h00);
    sel(1);
    rd("R10 status write ignored", ST, 12, 8'h01);
    wr(1, HI, 13, 8'h5C);
    rd("R10 write without select", HI, 13, 8'h00);
    rd("R10 status without select", ST, 13, 8'h41);

    // random traffic against the model
    @(negedge clk); hold = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if ($urandom_range(15) == 0) cs_n = ~cs_n;
      host_wr_valid = ($urandom_range(1) == 1);
      host_wr_first = ($urandom_range(3) == 0);
      host_wr_ferr  = ($urandom_range(7) == 0);
      host_wr_addr  = 6'($urandom_range(47));
      host_wr_data  = 8'($urandom);
      rx_valid      = ($urandom_range(3) == 0);
      rx_slot       = 4'($urandom);
      rx_word       = 16'($urandom);
      rx_crc_bad    = ($urandom_range(1) == 1);
      tx_take       = ($urandom_range(3) == 0);
      tx_slot       = 4'($urandom);
      chan_off      = ($urandom_range(63) == 0) ? 4'($urandom) : 4'b0000;
    end
    @(negedge clk);
    host_wr_valid = 0; rx_valid = 0; tx_take = 0; chan_off = 0; cs_n = 1;
    repeat (4) @(negedge clk);
    summary();
  end

endmodule